// File: doc/BRIEF.md
# Burst Address Generator

This block produces the word address for a short burst into a synchronous memory. A cycle starts when either of two active-low load strobes is sampled low. The block then captures the external address: the upper bits pass straight to the output, and the low bits become the burst start value. On later edges an active-low step input moves the burst to its next beat, but only when neither strobe is low. The same step rule applies to read bursts and write bursts, so a write beat that is accepted together with a low step also moves the address.

The low bits follow one of two wrap orders, chosen by a static order input. In interleaved order (order input high, which is the state when the pin is left pulled up), the low bits are the start value XOR a beat counter. In linear order (order input low), they are the start value plus the beat counter, modulo the burst length. The beat counter is kept apart from the captured start value and wraps after the last beat, so a burst that keeps stepping repeats its sequence. All outputs are registered.

Top module: `burst_addr_gen`

## Requirements
- R1: After synchronous reset, `addr_out` is 0, `beat_idx` is 0 and `addr_vld` is 0.
- R2: On an edge where `ld_a_n` or `ld_b_n` (or both) is low, the next cycle shows `addr_out` equal to `addr_in`, with `beat_idx` 0 and `addr_vld` 1.
- R3: `step_n` has no effect on an edge that loads: the loaded address appears with `beat_idx` 0 even when `step_n` is low.
- R4: On an edge where both strobes are high, `step_n` is low and `addr_vld` is 1, `beat_idx` increments by one, modulo 2^BEAT_W.
- R5: With `order_ilv` = 1, the low BEAT_W bits of `addr_out` after a step equal the start value XOR `beat_idx`. From a start of 01 the sequence is 01, 00, 11, 10.
- R6: With `order_ilv` = 0, the low BEAT_W bits of `addr_out` after a step equal (start value + `beat_idx`) modulo 2^BEAT_W. From a start of 01 the sequence is 01, 10, 11, 00.
- R7: On an edge where both strobes and `step_n` are high, `addr_out` and `beat_idx` keep their values.
- R8: Bits above BEAT_W of `addr_out` change only on a loading edge.
- R9: After the last beat of a burst the counter wraps, and the next step returns the low bits to the start value.
- R10: A step before the first load after reset has no effect: `addr_out`, `beat_idx` and `addr_vld` stay at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_a_n | input | 1 | First load strobe, active low |
| ld_b_n | input | 1 | Second load strobe, active low |
| step_n | input | 1 | Burst step request, active low |
| order_ilv | input | 1 | Static wrap order: 1 selects interleaved, 0 selects linear |
| addr_in | input | ADDR_W | External address captured on a load |
| addr_out | output | ADDR_W | Current burst address, registered |
| addr_vld | output | 1 | High once an address has been loaded since reset |
| beat_idx | output | BEAT_W | Current beat number within the burst |

## Verification
The bench sweeps both wrap orders, every low start value, and several upper-bit patterns (all zeros, all ones, alternating). Each burst runs one step past its length, which separates the XOR order from the add order and shows the wrap. The load strobes are used one at a time and together, and some loads are given with step low, which shows that either strobe loads and that a step on the load edge is ignored. Holding cycles show that the address is kept. Steps given before any load show that the block stays idle until the first address arrives.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef struct packed {
    logic load;
    logic step;
  } bag_ctl_t;

endpackage

// File: rtl/bag_strobe_decode.sv
module bag_strobe_decode
  import burst_addr_pkg::*;
(
  input  logic     ld_a_n,
  input  logic     ld_b_n,
  input  logic     step_n,
  input  logic     loaded,
  output bag_ctl_t ctl
);

  // Either strobe starts a cycle; a step is honoured only when both are idle.
  always_comb begin
    ctl.load = ~ld_a_n | ~ld_b_n;
    ctl.step = ld_a_n & ld_b_n & ~step_n & loaded;
  end

endmodule

// File: rtl/bag_beat_counter.sv
module bag_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [BEAT_W-1:0] cnt_q,
  output logic [BEAT_W-1:0] cnt_nxt
);

  always_comb begin
    if (clr)      cnt_nxt = '0;
    else if (inc) cnt_nxt = cnt_q + BEAT_W'(1);
    else          cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/bag_order_map.sv
module bag_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic              ilv,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low
);

  logic [BEAT_W-1:0] xor_low;
  logic [BEAT_W-1:0] add_low;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
    assign xor_low[i] = start[i] ^ beat[i];
  end

  assign add_low = start + beat;

  always_comb begin
    low = ilv ? xor_low : add_low;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_a_n,
  input  logic              ld_b_n,
  input  logic              step_n,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_vld,
  output logic [BEAT_W-1:0] beat_idx
);

  bag_ctl_t          ctl;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] cnt_nxt;
  logic [BEAT_W-1:0] low_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;
  order_e            order;

  assign order = order_e'(order_ilv);

  bag_strobe_decode u_dec (
    .ld_a_n (ld_a_n),
    .ld_b_n (ld_b_n),
    .step_n (step_n),
    .loaded (vld_q),
    .ctl    (ctl)
  );

  bag_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (ctl.load),
    .inc     (ctl.step),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  bag_order_map #(.BEAT_W(BEAT_W)) u_map (
    .ilv   (order == ORD_INTERLEAVE),
    .start (start_q),
    .beat  (cnt_nxt),
    .low   (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      addr_q  <= '0;
      vld_q   <= 1'b0;
    end else if (ctl.load) begin
      start_q <= addr_in[BEAT_W-1:0];
      addr_q  <= addr_in;
      vld_q   <= 1'b1;
    end else if (ctl.step) begin
      addr_q[BEAT_W-1:0] <= low_nxt;
    end
  end

  assign addr_out = addr_q;
  assign addr_vld = vld_q;
  assign beat_idx = cnt_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_a_n,
  input logic              ld_b_n,
  input logic              step_n,
  input logic              order_ilv,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_vld,
  input logic [BEAT_W-1:0] beat_idx
);

  // R2 R3
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_a_n || !ld_b_n) |=> (addr_out == $past(addr_in)) && (beat_idx == '0) && addr_vld);

  // R4
  step_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_a_n && ld_b_n && !step_n && addr_vld) |=> beat_idx == BEAT_W'($past(beat_idx) + 1'b1));

  // R5
  ilv_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_a_n && ld_b_n && !step_n && addr_vld && order_ilv) |=>
      ((addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0])) ==
       ($past(beat_idx) ^ BEAT_W'($past(beat_idx) + 1'b1))));

  // R6
  lin_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_a_n && ld_b_n && !step_n && addr_vld && !order_ilv) |=>
      addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_a_n && ld_b_n && step_n) |=> $stable(addr_out) && $stable(beat_idx));

  // R8
  upper_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_a_n && ld_b_n) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_a_n && ld_b_n && !addr_vld) |=> !addr_vld && $stable(addr_out) && $stable(beat_idx));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ld_a_n    (ld_a_n),
  .ld_b_n    (ld_b_n),
  .step_n    (step_n),
  .order_ilv (order_ilv),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .addr_vld  (addr_vld),
  .beat_idx  (beat_idx)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 19;
  localparam int BW = 2;
  localparam int NB = 1 << BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_a_n = 1'b1;
  logic          ld_b_n = 1'b1;
  logic          step_n = 1'b1;
  logic          order_ilv = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          addr_vld;
  logic [BW-1:0] beat_idx;

  int n_chk = 0;
  int n_err = 0;

  // expected state
  int            m_start = 0;
  int            m_beat = 0;
  logic [AW-1:0] m_addr = '0;
  logic          m_vld = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) u0 (
    .clk(clk), .rst(rst), .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .step_n(step_n),
    .order_ilv(order_ilv), .addr_in(addr_in), .addr_out(addr_out),
    .addr_vld(addr_vld), .beat_idx(beat_idx)
  );

  task automatic check(input string tag);
    logic [AW+BW:0] act, exp;
    act = {addr_vld, beat_idx, addr_out};
    exp = {m_vld, BW'(m_beat), m_addr};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: vld/beat/addr actual %0b/%0d/%h expected %0b/%0d/%h",
               tag, addr_vld, beat_idx, addr_out, m_vld, m_beat, m_addr);
    end
  endtask

  // one clock with given inputs; model updated from the requirements
  task automatic cycle(input logic a_n, input logic b_n, input logic s_n,
                       input logic [AW-1:0] ain, input string tag);
    int low;
    ld_a_n = a_n; ld_b_n = b_n; step_n = s_n; addr_in = ain;
    @(posedge clk);
    if (!a_n || !b_n) begin
      m_start = int'(ain[BW-1:0]);
      m_beat  = 0;
      m_addr  = ain;
      m_vld   = 1'b1;
    end else if (!s_n && m_vld) begin
      m_beat = (m_beat + 1) % NB;
      low = order_ilv ? (m_start ^ m_beat) : ((m_start + m_beat) % NB);
      m_addr[BW-1:0] = BW'(low);
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] uppers [3];
    logic [AW-1:0] base;
    uppers[0] = '0;
    uppers[1] = '1;
    uppers[2] = AW'(19'h2AAAA);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset");

    // R10: steps before any load
    for (int i = 0; i < 3; i++) cycle(1, 1, 0, AW'(19'h12345), "R10 step before load");

    for (int m = 0; m < 2; m++) begin
      order_ilv = m[0];
      for (int s = 0; s < NB; s++) begin
        for (int u = 0; u < 3; u++) begin
          base = {uppers[u][AW-1:BW], BW'(s)};
          case ((s + u) % 3)
            0: cycle(0, 1, 1, base, "R2 load via first strobe");
            1: cycle(1, 0, 0, base, "R3 load with step low, second strobe");
            default: cycle(0, 0, 0, base, "R3 load with both strobes and step low");
          endcase
          for (int b = 1; b <= NB; b++) begin
            if (b == NB)      cycle(1, 1, 0, '0, "R9 wrap to start");
            else if (m == 1)  cycle(1, 1, 0, '0, "R5 interleaved step");
            else              cycle(1, 1, 0, '0, "R6 linear step");
          end
          cycle(1, 1, 0, '0, "R4 step after wrap");
          cycle(1, 1, 1, '1, "R7 hold");
          n_chk++;
          if (addr_out[AW-1:BW] !== uppers[u][AW-1:BW]) begin
            n_err++;
            $display("FAIL R8 upper bits: actual %h expected %h",
                     addr_out[AW-1:BW], uppers[u][AW-1:BW]);
          end
        end
      end
    end

    // fixed sequences from the requirements, start 01
    order_ilv = 1'b1;
    cycle(0, 1, 1, AW'(1), "R5 start 01");
    cycle(1, 1, 0, '0, "R5 seq 00");
    n_chk++; if (addr_out[1:0] !== 2'b00) begin n_err++; $display("FAIL R5 seq: actual %b expected 00", addr_out[1:0]); end
    cycle(1, 1, 0, '0, "R5 seq 11");
    n_chk++; if (addr_out[1:0] !== 2'b11) begin n_err++; $display("FAIL R5 seq: actual %b expected 11", addr_out[1:0]); end
    order_ilv = 1'b0;
    cycle(1, 0, 1, AW'(1), "R6 start 01");
    cycle(1, 1, 0, '0, "R6 seq 10");
    n_chk++; if (addr_out[1:0] !== 2'b10) begin n_err++; $display("FAIL R6 seq: actual %b expected 10", addr_out[1:0]); end
    cycle(1, 1, 0, '0, "R6 seq 11");
    cycle(1, 1, 0, '0, "R6 seq 00");
    n_chk++; if (addr_out[1:0] !== 2'b00) begin n_err++; $display("FAIL R6 seq: actual %b expected 00", addr_out[1:0]); end

    // reset again mid-burst
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_beat = 0; m_addr = '0; m_vld = 1'b0; m_start = 0;
    check("R1 reset mid-burst");
    cycle(1, 1, 0, '0, "R10 step after reset");

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule